// File: doc/BRIEF.md
# Resource-Shared Second-Order Recursive Filter

This block computes one output of a second-order recursive filter for each input sample. It uses exactly one adder and one multiplier. A small step counter acts as the controller. In each of eight consecutive control steps it selects the operands for the shared adder and the shared multiplier, and it picks which scratch register takes each result. Two state words carry the filter history from one sample to the next. Three coefficient inputs are held constant by the surrounding logic.

A sample is offered on `x_in` together with a one-cycle `start` while the block is idle. The first step runs in the same clock edge that accepts the sample. The remaining seven steps follow on the next seven edges. On the last step both state words update, the new output appears on `y_out` and `done` rises for one cycle. Three scratch registers hold all the intermediate values. Each register is reused once the value it holds is no longer needed.

Top module: `rfilt2_shared`

## Requirements
- R1: All values are 8 bits, and every sum and product keeps only its low 8 bits. With state words t1 and t2, a sample x gives u = x + t2, v = u·k_fb + t2, w = v + t1 and the output y = k_out·(u + v).
- R2: After a sample completes, the state becomes t1 = w + k_ofs + t1_old and t2 = t1_new + w. Every step of a sample uses the state from before that sample, so the next sample's output reflects exactly this update.
- R3: A `start` seen while idle at clock edge E causes `done` to be high during the cycle that follows edge E+7.
- R4: `done` is high for exactly one cycle per accepted sample.
- R5: `y_out` changes only at the edge that raises `done`, and it keeps its value until the next sample completes.
- R6: `start` and `x_in` are ignored while a sample is in progress. The result and the completion time of the running sample are unaffected, and no extra `done` follows.
- R7: A synchronous reset returns the block to idle, clears both state words to 0, and drives `y_out` and `done` to 0.
- R8: A new `start` may be given in the cycle in which `done` is high, and that sample is accepted without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Offers `x_in` as a new sample when idle |
| x_in | input | 8 | Input sample |
| k_fb | input | 8 | Coefficient that multiplies the first partial sum |
| k_ofs | input | 8 | Coefficient added into the new t1 |
| k_out | input | 8 | Output scaling coefficient |
| y_out | output | 8 | Filter output, held between completions |
| done | output | 1 | One-cycle pulse marking a new `y_out` |

## Verification
The bench sweeps every sample value against several coefficient sets and carries the state from sample to sample. A schedule that reads a state word after it has been updated, or that reuses a scratch register too early, produces output that drifts from the arithmetic model within a few samples. Products with large operands are included, so a design that kept the wrong product bits or saturated instead of wrapping gives the wrong value. The bench also pulses `start` in the middle of a sample, restarts in the `done` cycle, and resets part-way through a sample. A design that accepted the stray start would corrupt the running sample or emit a second pulse. A design that lost the back-to-back start would hang. A design whose reset left the state alone would carry old history into the next output.

// File: rtl/rfilt2_shared.sv
module rfilt2_shared #(
  parameter int W = 8,
  parameter int STEPS = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] k_fb,
  input  logic [W-1:0] k_ofs,
  input  logic [W-1:0] k_out,
  output logic [W-1:0] y_out,
  output logic         done
);
  localparam int SW = $clog2(STEPS);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  logic          busy;
  logic [SW-1:0] step;
  logic [W-1:0]  t1, t2, r_a, r_b, r_c, y_acc;
  logic [W-1:0]  add_a, add_b, mul_a, mul_b, sum, prod;
  logic [2*W-1:0] mul_full;

  always_comb begin
    add_a = '0;
    add_b = '0;
    mul_a = '0;
    mul_b = '0;
    if (!busy) begin
      add_a = x_in;
      add_b = t2;
    end else begin
      case (step)
        SW'(1): begin mul_a = r_a; mul_b = k_fb; end
        SW'(2): begin add_a = r_b; add_b = t2; end
        SW'(3): begin add_a = r_a; add_b = r_c; end
        SW'(4): begin add_a = r_c; add_b = t1; mul_a = r_b; mul_b = k_out; end
        SW'(5): begin add_a = r_a; add_b = k_ofs; end
        SW'(6): begin add_a = r_b; add_b = t1; end
        SW'(7): begin add_a = r_c; add_b = r_a; end
        default: ;
      endcase
    end
  end

  assign sum      = add_a + add_b;
  assign mul_full = mul_a * mul_b;
  assign prod     = mul_full[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      step  <= '0;
      t1    <= '0;
      t2    <= '0;
      r_a   <= '0;
      r_b   <= '0;
      r_c   <= '0;
      y_acc <= '0;
      y_out <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          r_a  <= sum;
          busy <= 1'b1;
          step <= SW'(1);
        end
      end else begin
        case (step)
          SW'(1): r_b <= prod;
          SW'(2): r_c <= sum;
          SW'(3): r_b <= sum;
          SW'(4): begin r_a <= sum; y_acc <= prod; end
          SW'(5): r_b <= sum;
          SW'(6): r_c <= sum;
          default: ;
        endcase
        if (step == LAST) begin
          t2    <= sum;
          t1    <= r_c;
          y_out <= y_acc;
          done  <= 1'b1;
          busy  <= 1'b0;
          step  <= '0;
        end else begin
          step <= step + SW'(1);
        end
      end
    end
  end

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_last_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && step == LAST) |=> (done && !busy));
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && step != LAST) |=> (busy && !done));
  p_state_held_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && step != LAST) |=> ($stable(t1) && $stable(t2)));
  p_y_held_r5: assert property (@(posedge clk) disable iff (rst)
    !(busy && step == LAST) |=> $stable(y_out));
  p_reset_idle_r7: assert property (@(posedge clk)
    rst |=> (!busy && !done && t1 == '0 && t2 == '0 && y_out == '0));
endmodule

// File: tb/rfilt2_shared_tb_top.sv
module rfilt2_shared_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] x_in = '0, k_fb = '0, k_ofs = '0, k_out = '0;
  logic [7:0] y_out;
  logic done;
  int n_chk = 0, n_bad = 0;
  logic [7:0] m1 = '0, m2 = '0;

  always #2.5 clk = ~clk;

  rfilt2_shared dut_i (
    .clk(clk), .rst(rst), .start(start), .x_in(x_in), .k_fb(k_fb),
    .k_ofs(k_ofs), .k_out(k_out), .y_out(y_out), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] x);
    logic [7:0] u, v, w, z, y;
    u = x + m2;
    v = 8'(u * k_fb) + m2;
    w = v + m1;
    z = w + k_ofs + m1;
    y = 8'(k_out * 8'(u + v));
    m1 = z;
    m2 = z + w;
    return y;
  endfunction

  // Sample offered at the current negedge; optional stray start mid-run.
  task automatic run(input logic [7:0] x, input bit stray, input bit chk_pulse);
    logic [7:0] exp_y, held;
    int n;
    exp_y = model(x);
    held = y_out;
    start = 1'b1;
    x_in = x;
    n = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      if (stray && n == 2) begin start = 1'b1; x_in = ~x; end
      n++;
      if (!done && y_out != held) check("R5 y_out moved early", y_out, held);
    end while (!done && n < 20);
    check("R3 latency", n, 8);
    check("R1 output", y_out, exp_y);
    if (chk_pulse) begin
      @(negedge clk);
      check("R4 single pulse", done, 0);
      check("R5 y held", y_out, exp_y);
      if (stray) begin
        repeat (8) @(negedge clk);
        check("R6 no extra done", done, 0);
        check("R6 y unchanged", y_out, exp_y);
      end
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R7 reset y_out", y_out, 0);
    check("R7 reset done", done, 0);
    k_fb = 8'd3; k_ofs = 8'd5; k_out = 8'd7;
    run(8'd1, 0, 1);
    run(8'd2, 0, 1);
    // R2 / R1: full sweep of x under several coefficient sets, state carried on
    for (int s = 0; s < 4; s++) begin
      case (s)
        0: begin k_fb = 8'd0;   k_ofs = 8'd0;   k_out = 8'd1;   end
        1: begin k_fb = 8'd255; k_ofs = 8'd128; k_out = 8'd255; end
        2: begin k_fb = 8'd17;  k_ofs = 8'd201; k_out = 8'd99;  end
        default: begin k_fb = 8'd128; k_ofs = 8'd1; k_out = 8'd64; end
      endcase
      for (int x = 0; x < 256; x++) run(8'(x), 0, (x % 64) == 0);
    end
    // R8: back-to-back starts in the done cycle
    k_fb = 8'd9; k_ofs = 8'd33; k_out = 8'd5;
    for (int i = 0; i < 16; i++) run(8'(i * 37), 0, 0);
    @(negedge clk);
    // R6: stray start while busy
    run(8'd77, 1, 1);
    run(8'd200, 1, 1);
    // R7: reset in the middle of a sample
    start = 1'b1; x_in = 8'd55;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7 done cleared", done, 0);
    check("R7 y_out cleared", y_out, 0);
    repeat (10) @(negedge clk);
    check("R7 no done after reset", done, 0);
    m1 = '0; m2 = '0;
    run(8'd123, 0, 1);
    run(8'd45, 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule